// File: doc/BRIEF.md
# Host bus cycle decoder

This block is board-level glue that sits beside a host processor bus. In the clock where the processor's active-low address strobe is asserted, it captures the three cycle-definition status bits, the eight active-low byte enables and the 16-bit I/O port address. From these it forms a one-hot command vector: interrupt acknowledge, special cycle, I/O read, I/O write, code fetch, memory read, memory write, or invalid. The command stays registered until the active-low cycle-end ready is seen, and is then cleared.

Special cycles get a second level of decoding. The single active byte enable is turned into a one-clock event pulse: shutdown, cache flush, halt, write-back, flush acknowledge or branch trace. A shutdown event starts a fixed-length soft-reset request back to the processor. A one-bit phase flag tells the first interrupt-acknowledge cycle of a pair from the second. A set of parameterised address comparators forms chip selects from the captured port address while an I/O command is active.

Top module: `host_cycle_decoder`

## Requirements
- R1: Status bits, byte enables and port address are sampled only at a rising clock edge where `addr_strobe_n` is 0. Changes while the strobe is 1 have no effect on any output.
- R2: The status triple k = {cyc_mem, cyc_data, cyc_write} sets exactly one `cmd` bit. For every k other than 1, that bit is `cmd[k]`, so 0 = interrupt acknowledge, 2 = I/O read, 3 = I/O write, 4 = code fetch, 6 = memory read and 7 = memory write. The reserved value 5 sets `cmd[5]`, the invalid flag.
- R3: The command appears in the clock after the strobe edge. It holds through any number of clocks with `rdy_n` = 1, and it is all zero in the clock after an edge where `rdy_n` = 0 and the strobe is 1. A strobe at the same edge as a ready loads the new cycle.
- R4: For k = 1, if exactly one of `byte_en_n[5:0]` is 0 and `byte_en_n[7:6]` = 2'b11, then `cmd[1]` is set. In that case `spec_evt[i]` pulses for exactly one clock after the strobe edge, where i is the index of the low enable. The events are 0 shutdown, 1 cache flush, 2 halt, 3 write-back, 4 flush acknowledge and 5 branch trace.
- R5: For k = 1 with any other pattern of byte enables (none low, two or more low, or bit 6 or 7 low), `cmd[5]` (invalid) is set and no `spec_evt` bit pulses.
- R6: A shutdown event drives `init_req` to 1 for exactly INIT_CLKS clocks (default 4), starting in the clock after the strobe edge.
- R7: `inta_second` is 0 during the first interrupt-acknowledge cycle and 1 during the one that follows it. Any other cycle type resets the pairing, so the next acknowledge counts as a first one again.
- R8: `chip_sel[i]` is 1 only while `cmd[2]` or `cmd[3]` is held and (captured port & mask i) equals base i. The defaults are select 0 for ports 0040H-0043H (timer) and select 1 for ports 0020H-0021H.
- R9: While `rst` is 1 at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe_n | input | 1 | Active-low address strobe marking a new cycle |
| cyc_mem | input | 1 | 1 = memory, 0 = I/O |
| cyc_data | input | 1 | 1 = data, 0 = code or control |
| cyc_write | input | 1 | 1 = write, 0 = read |
| byte_en_n | input | 8 | Active-low byte enables |
| io_port | input | 16 | I/O port address |
| rdy_n | input | 1 | Active-low cycle-end ready |
| cmd | output | 8 | One-hot command, indexed by status triple; bit 5 is invalid |
| spec_evt | output | 6 | One-clock special-cycle event pulses |
| init_req | output | 1 | Soft-reset request pulse |
| inta_second | output | 1 | Marks the second acknowledge cycle of a pair |
| chip_sel | output | NUM_CS | Example I/O chip selects |

## Verification
Several properties are checked on every clock: the command stays one-hot, it holds through wait states, it clears after ready, an event pulse is always paired with a special-cycle command, the acknowledge phase flag only appears with an acknowledge command, and a chip select only appears with an I/O command. Other behaviours can only be shown by the bench's scenarios. These are the exact mapping of each status code and each byte-enable pattern, the rejection of malformed special cycles, the four-clock length of the soft-reset pulse, the pairing and reset of acknowledge cycles, and the fact that inputs seen outside the strobe clock are ignored.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

    localparam int NUM_CMD = 8;
    localparam int NUM_EVT = 6;
    localparam int BE_W    = 8;
    localparam int PORT_W  = 16;

    typedef enum logic [2:0] {
        ST_INTA  = 3'd0,
        ST_SPEC  = 3'd1,
        ST_IORD  = 3'd2,
        ST_IOWR  = 3'd3,
        ST_FETCH = 3'd4,
        ST_RSVD  = 3'd5,
        ST_MEMRD = 3'd6,
        ST_MEMWR = 3'd7
    } status_e;

    typedef struct packed {
        logic [NUM_CMD-1:0] cmd;
        logic [NUM_EVT-1:0] evt;
    } decode_t;

    // Second-level decode: exactly one low enable among the event lanes,
    // upper lanes idle; anything else yields no event.
    function automatic logic [NUM_EVT-1:0] spec_events(logic [BE_W-1:0] be_n);
        logic [NUM_EVT-1:0] act;
        act = ~be_n[NUM_EVT-1:0];
        if ($countones(act) == 1 && (&be_n[BE_W-1:NUM_EVT]))
            return act;
        return '0;
    endfunction

    function automatic decode_t decode_status(status_e st, logic [BE_W-1:0] be_n);
        decode_t d;
        d.cmd = '0;
        d.evt = '0;
        if (st == ST_SPEC) begin
            d.evt = spec_events(be_n);
            if (d.evt == '0)
                d.cmd[int'(ST_RSVD)] = 1'b1;
            else
                d.cmd[int'(ST_SPEC)] = 1'b1;
        end else begin
            d.cmd[int'(st)] = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/hcd_status_decode.sv
module hcd_status_decode
    import hcd_pkg::*;
(
    input  status_e              st,
    input  logic [BE_W-1:0]      be_n,
    output decode_t              dec
);
    always_comb begin
        dec = decode_status(st, be_n);
    end
endmodule

// File: rtl/hcd_cycle_latch.sv
module hcd_cycle_latch
    import hcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe_n,
    input  logic                 ready_n,
    input  status_e              st,
    input  decode_t              dec,
    input  logic [PORT_W-1:0]    port_in,
    output logic [NUM_CMD-1:0]   cmd_q,
    output logic [NUM_EVT-1:0]   evt_q,
    output logic [PORT_W-1:0]    port_q,
    output logic                 inta_2nd_q
);
    logic ack_half;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            evt_q      <= '0;
            port_q     <= '0;
            inta_2nd_q <= 1'b0;
            ack_half   <= 1'b0;
        end else begin
            evt_q <= '0;
            if (!strobe_n) begin
                cmd_q  <= dec.cmd;
                evt_q  <= dec.evt;
                port_q <= port_in;
                if (st == ST_INTA) begin
                    inta_2nd_q <= ack_half;
                    ack_half   <= ~ack_half;
                end else begin
                    inta_2nd_q <= 1'b0;
                    ack_half   <= 1'b0;
                end
            end else if (!ready_n) begin
                cmd_q      <= '0;
                inta_2nd_q <= 1'b0;
            end
        end
    end

    a_r2_onehot_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_q));

    a_r3_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (strobe_n && ready_n) |=> $stable(cmd_q));

    a_r3_clear_ready: assert property (@(posedge clk) disable iff (rst)
        (strobe_n && !ready_n) |=> (cmd_q == '0));

    a_r4_evt_pulse: assert property (@(posedge clk) disable iff (rst)
        (evt_q != '0) |=> (evt_q == '0 || $past(!strobe_n)));

    a_r5_evt_needs_special: assert property (@(posedge clk) disable iff (rst)
        (evt_q != '0) |-> (cmd_q[int'(ST_SPEC)] && $onehot(evt_q)));

    a_r7_second_is_ack: assert property (@(posedge clk) disable iff (rst)
        inta_2nd_q |-> cmd_q[int'(ST_INTA)]);
endmodule

// File: rtl/hcd_init_pulse.sv
module hcd_init_pulse #(
    parameter int INIT_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic init_req
);
    localparam int CW = $clog2(INIT_CLKS + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (trig)
            remain <= CW'(INIT_CLKS);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign init_req = (remain != '0);

    a_r6_trig_starts: assert property (@(posedge clk) disable iff (rst)
        trig |=> init_req);

    a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(init_req) |-> $past(trig));
endmodule

// File: rtl/hcd_io_select.sv
module hcd_io_select
    import hcd_pkg::*;
#(
    parameter int                     NUM_CS  = 2,
    parameter logic [NUM_CS*16-1:0]   CS_BASE = {16'h0020, 16'h0040},
    parameter logic [NUM_CS*16-1:0]   CS_MASK = {16'hFFFE, 16'hFFFC}
) (
    input  logic                 io_active,
    input  logic [PORT_W-1:0]    port_q,
    output logic [NUM_CS-1:0]    cs
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs[i] = io_active &&
                       ((port_q & CS_MASK[i*16 +: 16]) == CS_BASE[i*16 +: 16]);
    end
endmodule

// File: rtl/host_cycle_decoder.sv
module host_cycle_decoder
    import hcd_pkg::*;
#(
    parameter int                     INIT_CLKS = 4,
    parameter int                     NUM_CS    = 2,
    parameter logic [NUM_CS*16-1:0]   CS_BASE   = {16'h0020, 16'h0040},
    parameter logic [NUM_CS*16-1:0]   CS_MASK   = {16'hFFFE, 16'hFFFC}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 addr_strobe_n,
    input  logic                 cyc_mem,
    input  logic                 cyc_data,
    input  logic                 cyc_write,
    input  logic [BE_W-1:0]      byte_en_n,
    input  logic [PORT_W-1:0]    io_port,
    input  logic                 rdy_n,
    output logic [NUM_CMD-1:0]   cmd,
    output logic [NUM_EVT-1:0]   spec_evt,
    output logic                 init_req,
    output logic                 inta_second,
    output logic [NUM_CS-1:0]    chip_sel
);
    status_e            st;
    decode_t            dec;
    logic [PORT_W-1:0]  port_q;
    logic               io_active;

    assign st = status_e'({cyc_mem, cyc_data, cyc_write});

    hcd_status_decode u_dec (
        .st   (st),
        .be_n (byte_en_n),
        .dec  (dec)
    );

    hcd_cycle_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .strobe_n   (addr_strobe_n),
        .ready_n    (rdy_n),
        .st         (st),
        .dec        (dec),
        .port_in    (io_port),
        .cmd_q      (cmd),
        .evt_q      (spec_evt),
        .port_q     (port_q),
        .inta_2nd_q (inta_second)
    );

    hcd_init_pulse #(.INIT_CLKS(INIT_CLKS)) u_init (
        .clk      (clk),
        .rst      (rst),
        .trig     (!addr_strobe_n && dec.evt[0]),
        .init_req (init_req)
    );

    assign io_active = cmd[int'(ST_IORD)] | cmd[int'(ST_IOWR)];

    hcd_io_select #(
        .NUM_CS  (NUM_CS),
        .CS_BASE (CS_BASE),
        .CS_MASK (CS_MASK)
    ) u_sel (
        .io_active (io_active),
        .port_q    (port_q),
        .cs        (chip_sel)
    );

    a_r8_cs_needs_io: assert property (@(posedge clk) disable iff (rst)
        (chip_sel != '0) |-> (cmd[2] || cmd[3]));

    a_r6_shutdown_init: assert property (@(posedge clk) disable iff (rst)
        spec_evt[0] |-> init_req);
endmodule

// File: tb/sim_host_cycle_decoder.sv
module sim_host_cycle_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_strobe_n = 1'b1;
    logic        cyc_mem = 1'b0, cyc_data = 1'b0, cyc_write = 1'b0;
    logic [7:0]  byte_en_n = 8'hFF;
    logic [15:0] io_port = '0;
    logic        rdy_n = 1'b1;
    logic [7:0]  cmd;
    logic [5:0]  spec_evt;
    logic        init_req;
    logic        inta_second;
    logic [1:0]  chip_sel;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    host_cycle_decoder u0 (
        .clk(clk), .rst(rst), .addr_strobe_n(addr_strobe_n),
        .cyc_mem(cyc_mem), .cyc_data(cyc_data), .cyc_write(cyc_write),
        .byte_en_n(byte_en_n), .io_port(io_port), .rdy_n(rdy_n),
        .cmd(cmd), .spec_evt(spec_evt), .init_req(init_req),
        .inta_second(inta_second), .chip_sel(chip_sel)
    );

    // {status[2:0], be_n[7:0], port[15:0], exp_cmd[7:0], exp_evt[5:0], exp_cs[1:0]}
    localparam int NV = 17;
    localparam logic [42:0] VEC [NV] = '{
        {3'b000, 8'hF0, 16'h0000, 8'h01, 6'h00, 2'b00},  // R2 ack
        {3'b001, 8'hFE, 16'h0000, 8'h02, 6'h01, 2'b00},  // R4 shutdown
        {3'b001, 8'hFD, 16'h0000, 8'h02, 6'h02, 2'b00},  // R4 flush
        {3'b001, 8'hFB, 16'h0000, 8'h02, 6'h04, 2'b00},  // R4 halt
        {3'b001, 8'hF7, 16'h0000, 8'h02, 6'h08, 2'b00},  // R4 write-back
        {3'b001, 8'hEF, 16'h0000, 8'h02, 6'h10, 2'b00},  // R4 flush ack
        {3'b001, 8'hDF, 16'h0000, 8'h02, 6'h20, 2'b00},  // R4 trace
        {3'b001, 8'hFC, 16'h0000, 8'h20, 6'h00, 2'b00},  // R5 two low
        {3'b001, 8'hFF, 16'h0000, 8'h20, 6'h00, 2'b00},  // R5 none low
        {3'b001, 8'h7E, 16'h0000, 8'h20, 6'h00, 2'b00},  // R5 upper lane low
        {3'b010, 8'hF7, 16'h0043, 8'h04, 6'h00, 2'b01},  // R8 timer read
        {3'b011, 8'hFE, 16'h0021, 8'h08, 6'h00, 2'b10},  // R8 second select
        {3'b010, 8'hEF, 16'h0044, 8'h04, 6'h00, 2'b00},  // R8 miss
        {3'b100, 8'h00, 16'h0043, 8'h10, 6'h00, 2'b00},  // R2 fetch
        {3'b101, 8'h00, 16'h0000, 8'h20, 6'h00, 2'b00},  // R2 reserved
        {3'b110, 8'h0F, 16'h0040, 8'h40, 6'h00, 2'b00},  // R2 memory read
        {3'b111, 8'hF0, 16'h0043, 8'h80, 6'h00, 2'b00}   // R8 memory, no select
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_cycle(input logic [2:0] s, input logic [7:0] be, input logic [15:0] p);
        @(negedge clk);
        addr_strobe_n = 1'b0;
        {cyc_mem, cyc_data, cyc_write} = s;
        byte_en_n = be;
        io_port = p;
        @(negedge clk);
        addr_strobe_n = 1'b1;
    endtask

    task automatic end_cycle();
        rdy_n = 1'b0;
        @(negedge clk);
        rdy_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int highs;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 cmd", 32'(cmd), 0);
        check("R9 evt", 32'(spec_evt), 0);
        check("R9 init", 32'(init_req), 0);
        check("R9 cs", 32'(chip_sel), 0);
        check("R9 inta", 32'(inta_second), 0);
        rst = 1'b0;

        // Table walk: R2 R4 R5 R8 and R3 clearing
        for (int i = 0; i < NV; i++) begin
            start_cycle(VEC[i][42:40], VEC[i][39:32], VEC[i][31:16]);
            check("R2 cmd", 32'(cmd), 32'(VEC[i][15:8]));
            check("R4 evt", 32'(spec_evt), 32'(VEC[i][7:2]));
            check("R8 cs", 32'(chip_sel), 32'(VEC[i][1:0]));
            end_cycle();
            check("R3 cleared", 32'(cmd), 0);
            check("R4 pulse one clock", 32'(spec_evt), 0);
            check("R8 cs off", 32'(chip_sel), 0);
        end

        // R1 and R3: inputs ignored outside strobe, command held in wait states
        repeat (6) @(negedge clk);
        start_cycle(3'b110, 8'h00, 16'h0000);
        {cyc_mem, cyc_data, cyc_write} = 3'b011;
        byte_en_n = 8'hFE;
        io_port = 16'h0043;
        repeat (3) @(negedge clk);
        check("R1 cmd unchanged", 32'(cmd), 32'h40);
        check("R1 no event", 32'(spec_evt), 0);
        check("R1 no init", 32'(init_req), 0);
        check("R1 no cs", 32'(chip_sel), 0);
        // R3: strobe at same edge as ready loads the new cycle
        @(negedge clk);
        addr_strobe_n = 1'b0;
        rdy_n = 1'b0;
        {cyc_mem, cyc_data, cyc_write} = 3'b100;
        @(negedge clk);
        addr_strobe_n = 1'b1;
        rdy_n = 1'b1;
        check("R3 strobe wins", 32'(cmd), 32'h10);
        end_cycle();

        // R6: shutdown gives init pulse of four clocks
        start_cycle(3'b001, 8'hFE, 16'h0000);
        highs = 0;
        for (int k = 0; k < 7; k++) begin
            if (init_req) highs++;
            @(negedge clk);
        end
        check("R6 init length", 32'(highs), 4);
        check("R6 init ended", 32'(init_req), 0);
        end_cycle();
        // R6: non-shutdown special gives no init
        start_cycle(3'b001, 8'hFB, 16'h0000);
        check("R6 halt no init", 32'(init_req), 0);
        end_cycle();

        // R7: acknowledge pairing
        start_cycle(3'b000, 8'hFF, 16'h0000);
        check("R7 first ack", 32'(inta_second), 0);
        end_cycle();
        start_cycle(3'b000, 8'hFF, 16'h0000);
        check("R7 second ack", 32'(inta_second), 1);
        end_cycle();
        check("R7 cleared", 32'(inta_second), 0);
        start_cycle(3'b000, 8'hFF, 16'h0000);
        end_cycle();
        start_cycle(3'b110, 8'h00, 16'h0000);
        end_cycle();
        start_cycle(3'b000, 8'hFF, 16'h0000);
        check("R7 reset by other cycle", 32'(inta_second), 0);
        end_cycle();

        // R9: reset mid-cycle
        start_cycle(3'b010, 8'hFF, 16'h0043);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid reset cmd", 32'(cmd), 0);
        check("R9 mid reset cs", 32'(chip_sel), 0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule